// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Status Word

This block receives asynchronous serial characters on a single line and hands them to a host through a one-character data-in buffer and an 8-bit status word. The block clock runs at a fixed multiple of the bit rate, set by the `OVERSAMPLE` parameter (16 by default). A falling edge on the line starts a candidate start bit. The line is checked again at the middle of that bit, and every later bit is sampled one bit period after the one before it. The character length is 5 to 8 data bits, received least significant bit first. An optional even or odd parity bit and one stop bit follow.

A finished character goes into the data-in buffer with its high bits cleared and its parity bit removed. The status word shows whether a character is ready, along with sticky parity, overrun and framing error flags. It also passes through the modem-ready and sync-detect inputs. A host read strobe empties the buffer. A command write sets the receiver enable, and the same write can clear the three error flags.

Top module: `serial_rx_status`

## Requirements
- R1: After reset the receiver is disabled, `rd_data` is 0, and the status bits 5..0 are all 0.
- R2: A start bit is accepted only if the line is still low at the middle sample of the bit (sample 8 of 16). A low pulse of 4 clocks produces no character.
- R3: Data bits are taken least significant bit first, one every 16 clocks. `cfg_data_bits` 00/01/10/11 selects 5/6/7/8 bits. Unused high bits of `rd_data` read as 0.
- R4: When `cfg_parity_en` is 1, a parity bit follows the data. `cfg_parity_odd`=0 expects an even count of ones over data and parity, and 1 expects an odd count. A mismatch sets status bit 3. The parity bit never appears in `rd_data`.
- R5: A stop bit sampled as 0 sets status bit 5 (framing error). The character is still loaded and marked ready.
- R6: Status bit 1 (ready) goes to 1 when a character is loaded. It goes to 0 after a `host_rd` strobe.
- R7: If a character completes while status bit 1 is still set, status bit 4 (overrun) goes to 1 and the new character replaces the buffer contents.
- R8: Status bits 3, 4 and 5 stay set until a `cmd_wr` with `cmd_err_reset`=1. A `cmd_wr` with `cmd_err_reset`=0 leaves them set.
- R9: `cmd_wr` loads `cmd_rx_enable` as the receiver enable. While the enable is 0, no character is accepted: ready stays 0 and `rd_data` is unchanged.
- R10: Status bit 7 equals `modem_ready`, status bit 6 equals `sync_detect`, and status bits 0 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OVERSAMPLE times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_serial | input | 1 | Serial receive line, idle high |
| cfg_data_bits | input | 2 | Character length code: 5 + value |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cmd_wr | input | 1 | Command write strobe |
| cmd_rx_enable | input | 1 | Receiver enable value loaded on cmd_wr |
| cmd_err_reset | input | 1 | Clear error flags on cmd_wr |
| host_rd | input | 1 | Host read strobe for the data-in buffer |
| modem_ready | input | 1 | Modem on and in data mode |
| sync_detect | input | 1 | Sync-detect signal shown in the status word |
| rd_data | output | 8 | Data-in buffer |
| status | output | 8 | Status word |

## Verification
The main function is exercised with 8-bit characters that have alternating and clustered bit patterns. These show whether the data arrives least significant bit first or in reverse order. Five-bit and seven-bit characters with all high bits set show whether the padding is zeroed and whether the bit count is honoured. Characters with correct and deliberately wrong parity, in both even and odd modes, separate a parity fault from a data fault, because `rd_data` must be the same in both cases. A short low glitch, a zero stop bit, back-to-back characters without a read, and traffic while the receiver is disabled each target one flag or one rejection path.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    localparam int STAT_READY   = 1;
    localparam int STAT_PARERR  = 3;
    localparam int STAT_OVERRUN = 4;
    localparam int STAT_FRAMERR = 5;
    localparam int STAT_SYNC    = 6;
    localparam int STAT_MODEM   = 7;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b1;
                end else if (i == 0) begin
                    chain_q[i] <= din;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_line,
    input  logic [1:0]        cfg_data_bits,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    output logic              chr_valid,
    output logic [DATA_W-1:0] chr_data,
    output logic              chr_perr,
    output logic              chr_ferr
);
    localparam int CW   = $clog2(OVERSAMPLE);
    localparam int HALF = OVERSAMPLE / 2;
    localparam int IW   = $clog2(DATA_W + 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     bit_idx;
        logic [DATA_W-1:0] shreg;
        logic              par_acc;
        logic              perr;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic              out_perr;
        logic              out_ferr;
    } frame_t;

    frame_t frm_d, frm_q;
    logic [IW-1:0] nbits;
    logic          bit_end;

    assign nbits   = IW'(5) + IW'(cfg_data_bits);
    assign bit_end = (frm_q.cnt == CW'(OVERSAMPLE - 1));

    always_comb begin
        frm_d           = frm_q;
        frm_d.out_valid = 1'b0;
        case (frm_q.state)
            RX_IDLE: begin
                if (!rx_line) begin
                    frm_d.state = RX_START;
                    frm_d.cnt   = '0;
                end
            end
            RX_START: begin
                if (frm_q.cnt == CW'(HALF - 1)) begin
                    frm_d.cnt = '0;
                    if (!rx_line) begin
                        frm_d.state   = RX_DATA;
                        frm_d.bit_idx = '0;
                        frm_d.shreg   = '0;
                        frm_d.par_acc = 1'b0;
                        frm_d.perr    = 1'b0;
                    end else begin
                        frm_d.state = RX_IDLE;
                    end
                end else begin
                    frm_d.cnt = frm_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    frm_d.cnt     = '0;
                    frm_d.shreg   = {rx_line, frm_q.shreg[DATA_W-1:1]};
                    frm_d.par_acc = frm_q.par_acc ^ rx_line;
                    frm_d.bit_idx = frm_q.bit_idx + 1'b1;
                    if (frm_q.bit_idx == nbits - 1'b1) begin
                        frm_d.state = cfg_parity_en ? RX_PARITY : RX_STOP;
                    end
                end else begin
                    frm_d.cnt = frm_q.cnt + 1'b1;
                end
            end
            RX_PARITY: begin
                if (bit_end) begin
                    frm_d.cnt   = '0;
                    frm_d.perr  = ((frm_q.par_acc ^ rx_line) != cfg_parity_odd);
                    frm_d.state = RX_STOP;
                end else begin
                    frm_d.cnt = frm_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (bit_end) begin
                    frm_d.cnt       = '0;
                    frm_d.out_valid = 1'b1;
                    frm_d.out_data  = frm_q.shreg >> (IW'(DATA_W) - nbits);
                    frm_d.out_perr  = frm_q.perr;
                    frm_d.out_ferr  = !rx_line;
                    frm_d.state     = RX_IDLE;
                end else begin
                    frm_d.cnt = frm_q.cnt + 1'b1;
                end
            end
            default: frm_d.state = RX_IDLE;
        endcase
        if (!rx_en) begin
            frm_d.state = RX_IDLE;
            frm_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '{state: RX_IDLE, default: '0};
        end else begin
            frm_q <= frm_d;
        end
    end

    assign chr_valid = frm_q.out_valid;
    assign chr_data  = frm_q.out_data;
    assign chr_perr  = frm_q.out_perr;
    assign chr_ferr  = frm_q.out_ferr;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (frm_q.state == RX_IDLE && !chr_valid)); // R9
    AST_PAD_ZERO_5: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && cfg_data_bits == 2'b00) |-> (chr_data[DATA_W-1:5] == '0)); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |=> !chr_valid); // R6
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_perr,
    input  logic              chr_ferr,
    input  logic              cmd_wr,
    input  logic              cmd_rx_enable,
    input  logic              cmd_err_reset,
    input  logic              host_rd,
    input  logic              modem_ready,
    input  logic              sync_detect,
    output logic              rx_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);
    typedef struct packed {
        logic              enable;
        logic              ready;
        logic              ovr;
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] buffer;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_wr) begin
            st_d.enable = cmd_rx_enable;
            if (cmd_err_reset) begin
                st_d.ovr  = 1'b0;
                st_d.perr = 1'b0;
                st_d.ferr = 1'b0;
            end
        end
        if (host_rd) begin
            st_d.ready = 1'b0;
        end
        if (chr_valid) begin
            st_d.buffer = chr_data;
            if (st_q.ready && !host_rd) begin
                st_d.ovr = 1'b1;
            end
            st_d.ready = 1'b1;
            st_d.perr  = st_d.perr | chr_perr;
            st_d.ferr  = st_d.ferr | chr_ferr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status               = '0;
        status[STAT_READY]   = st_q.ready;
        status[STAT_PARERR]  = st_q.perr;
        status[STAT_OVERRUN] = st_q.ovr;
        status[STAT_FRAMERR] = st_q.ferr;
        status[STAT_SYNC]    = sync_detect;
        status[STAT_MODEM]   = modem_ready;
    end

    assign rx_en   = st_q.enable;
    assign rd_data = st_q.buffer;

    AST_READY_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |=> st_q.ready); // R6
    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !chr_valid) |=> !st_q.ready); // R6
    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && st_q.ready && !host_rd) |=> st_q.ovr); // R7
    AST_ERR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_err_reset && !chr_valid) |=> !(st_q.ovr || st_q.perr || st_q.ferr)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ovr || st_q.perr || st_q.ferr) && !(cmd_wr && cmd_err_reset))
        |=> (st_q.ovr || st_q.perr || st_q.ferr)); // R8
    AST_NO_LOAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.enable && !chr_valid) |=> $stable(st_q.buffer)); // R9
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_serial,
    input  logic [1:0]        cfg_data_bits,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cmd_wr,
    input  logic              cmd_rx_enable,
    input  logic              cmd_err_reset,
    input  logic              host_rd,
    input  logic              modem_ready,
    input  logic              sync_detect,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);
    logic              line_s;
    logic              rx_en;
    logic              chr_valid;
    logic [DATA_W-1:0] chr_data;
    logic              chr_perr;
    logic              chr_ferr;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_serial),
        .dout (line_s)
    );

    srx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .rx_line       (line_s),
        .cfg_data_bits (cfg_data_bits),
        .cfg_parity_en (cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd),
        .chr_valid     (chr_valid),
        .chr_data      (chr_data),
        .chr_perr      (chr_perr),
        .chr_ferr      (chr_ferr)
    );

    srx_status #(.DATA_W(DATA_W)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .chr_valid    (chr_valid),
        .chr_data     (chr_data),
        .chr_perr     (chr_perr),
        .chr_ferr     (chr_ferr),
        .cmd_wr       (cmd_wr),
        .cmd_rx_enable(cmd_rx_enable),
        .cmd_err_reset(cmd_err_reset),
        .host_rd      (host_rd),
        .modem_ready  (modem_ready),
        .sync_detect  (sync_detect),
        .rx_en        (rx_en),
        .rd_data      (rd_data),
        .status       (status)
    );
endmodule

// File: tb/tb_serial_rx_status.sv
`timescale 1ns/1ps
module tb_serial_rx_status;
    localparam int OS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_serial = 1'b1;
    logic [1:0] cfg_data_bits = 2'b11;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       cmd_wr = 1'b0;
    logic       cmd_rx_enable = 1'b0;
    logic       cmd_err_reset = 1'b0;
    logic       host_rd = 1'b0;
    logic       modem_ready = 1'b0;
    logic       sync_detect = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] status;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_rx_status dut (
        .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial),
        .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cmd_wr(cmd_wr),
        .cmd_rx_enable(cmd_rx_enable), .cmd_err_reset(cmd_err_reset),
        .host_rd(host_rd), .modem_ready(modem_ready), .sync_detect(sync_detect),
        .rd_data(rd_data), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic command(input bit en, input bit clr);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_rx_enable = en; cmd_err_reset = clr;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_err_reset = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic hold_line(input bit v);
        rx_serial = v;
        repeat (OS) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit stop_v);
        int nb = 5 + int'(cfg_data_bits);
        bit ones = 1'b0;
        @(negedge clk);
        hold_line(1'b0);
        for (int i = 0; i < nb; i++) begin
            hold_line(d[i]);
            ones ^= d[i];
        end
        if (cfg_parity_en) hold_line(ones ^ cfg_parity_odd ^ bad_par);
        hold_line(stop_v);
        rx_serial = 1'b1;
        repeat (OS) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 status after reset", status, 8'h00);
        check("R1 rd_data after reset", rd_data, 8'h00);
        send_char(8'h5A, 1'b0, 1'b1);
        check("R1 disabled at reset, no char", status[1], 0);
    endtask

    task automatic t_basic8();
        command(1'b1, 1'b0);
        cfg_data_bits = 2'b11; cfg_parity_en = 1'b0;
        send_char(8'hA5, 1'b0, 1'b1);
        check("R3 8-bit data 0xA5", rd_data, 8'hA5);
        check("R6 ready set", status[1], 1);
        check("R3 no errors", status[5:3], 0);
        host_read();
        check("R6 ready cleared by read", status[1], 0);
        send_char(8'h1E, 1'b0, 1'b1);
        check("R3 8-bit data 0x1E lsb first", rd_data, 8'h1E);
        host_read();
    endtask

    task automatic t_short();
        cfg_data_bits = 2'b00;
        send_char(8'hFF, 1'b0, 1'b1);
        check("R3 5-bit padded", rd_data, 8'h1F);
        host_read();
        cfg_data_bits = 2'b10;
        send_char(8'hD5, 1'b0, 1'b1);
        check("R3 7-bit padded", rd_data, 8'h55);
        host_read();
        cfg_data_bits = 2'b01;
        send_char(8'hEB, 1'b0, 1'b1);
        check("R3 6-bit padded", rd_data, 8'h2B);
        host_read();
    endtask

    task automatic t_parity();
        cfg_data_bits = 2'b10; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
        send_char(8'h41, 1'b0, 1'b1);
        check("R4 even good parity no error", status[3], 0);
        check("R4 parity stripped", rd_data, 8'h41);
        host_read();
        send_char(8'h43, 1'b1, 1'b1);
        check("R4 even bad parity flagged", status[3], 1);
        check("R4 data intact on parity error", rd_data, 8'h43);
        host_read();
        command(1'b1, 1'b1);
        cfg_parity_odd = 1'b1;
        send_char(8'h7F, 1'b0, 1'b1);
        check("R4 odd good parity no error", status[3], 0);
        host_read();
        send_char(8'h00, 1'b1, 1'b1);
        check("R4 odd bad parity flagged", status[3], 1);
        host_read();
        command(1'b1, 1'b1);
        cfg_parity_en = 1'b0;
    endtask

    task automatic t_framing();
        cfg_data_bits = 2'b11;
        send_char(8'h96, 1'b0, 1'b0);
        check("R5 framing error flagged", status[5], 1);
        check("R5 char still ready", status[1], 1);
        check("R5 char still loaded", rd_data, 8'h96);
        host_read();
        repeat (2*OS) @(negedge clk);
        check("R2 no false char after bad stop", status[1], 0);
        command(1'b1, 1'b1);
    endtask

    task automatic t_overrun();
        send_char(8'h11, 1'b0, 1'b1);
        send_char(8'h22, 1'b0, 1'b1);
        check("R7 overrun flagged", status[4], 1);
        check("R7 newest char kept", rd_data, 8'h22);
        host_read();
        command(1'b1, 1'b0);
        check("R8 error sticky without reset bit", status[4], 1);
        command(1'b1, 1'b1);
        check("R8 errors cleared by reset bit", status[5:3], 0);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rx_serial = 1'b0;
        repeat (4) @(negedge clk);
        rx_serial = 1'b1;
        repeat (12*OS) @(negedge clk);
        check("R2 short glitch rejected", status[1], 0);
    endtask

    task automatic t_disable();
        command(1'b0, 1'b0);
        send_char(8'hC3, 1'b0, 1'b1);
        check("R9 disabled, no ready", status[1], 0);
        check("R9 disabled, buffer unchanged", rd_data, 8'h22);
        command(1'b1, 1'b0);
        send_char(8'h3C, 1'b0, 1'b1);
        check("R9 re-enabled receives", rd_data, 8'h3C);
        host_read();
    endtask

    task automatic t_modem();
        @(negedge clk);
        modem_ready = 1'b1; sync_detect = 1'b0;
        #1 check("R10 modem bit", status & 8'hC5, 8'h80);
        sync_detect = 1'b1; modem_ready = 1'b0;
        #1 check("R10 sync bit", status & 8'hC5, 8'h40);
        sync_detect = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic8();
        t_short();
        t_parity();
        t_framing();
        t_overrun();
        t_glitch();
        t_disable();
        t_modem();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule